// File: doc/BRIEF.md
# JTAG Bit Sequence Shifter

This block drives the three JTAG output pins (test clock, mode select, data in) from a byte stream of sequence commands and can return what the target shifts back on its data-out pin. A command starts with a byte giving how many sequences follow. Each sequence starts with a one-byte descriptor that gives the number of test-clock pulses, one mode-select level held for the whole sequence and a capture flag. The packed data-in bytes for that sequence follow the descriptor. When the capture flag is set, the sampled data-out bits are packed into bytes and sent on a byte-wide output stream.

The test clock comes from the system clock through a divider that can be changed at run time. Each half period of the test clock lasts `clk_div + 1` system cycles. The test clock stays low whenever the block is not shifting. A state machine controls all of this:

- S_COUNT waits for the sequence-count byte.
- S_DESC takes a descriptor.
- S_LOAD takes the next data byte.
- S_SHIFT produces the clock pulses.
- S_EMIT offers a captured byte downstream.

The transitions are:

- S_COUNT→S_DESC on a nonzero count. S_COUNT stays in S_COUNT on a zero count.
- S_DESC→S_LOAD.
- S_LOAD→S_SHIFT.
- S_SHIFT→S_EMIT at the end of a byte or sequence when capture is set.
- S_SHIFT→S_LOAD at the end of a byte when capture is clear.
- S_SHIFT→S_DESC or S_COUNT at the end of a sequence when capture is clear.
- S_EMIT→S_LOAD, S_DESC or S_COUNT once the byte is accepted.

Top module: `jseq_shifter`

## Requirements
- R1: Descriptor bits 5:0 give the number of test-clock rising edges in the sequence, and the value 0 means 64.
- R2: Descriptor bit 6 sets the mode-select pin level, and that level is held on every rising edge of the sequence.
- R3: A sequence of n clocks takes ceil(n/8) data bytes. Bits are driven least significant bit first, and the data pin changes only while the test clock is low.
- R4: When descriptor bit 7 is set, the data-out pin is sampled at each rising edge and packed least significant bit first into ceil(n/8) output bytes, with unused high bits zero. When bit 7 is clear, no output byte is produced.
- R5: The first byte of a command gives the number of sequences that follow. A count of 0 produces no clocks, and the next byte is again read as a count.
- R6: Each high phase of the test clock lasts `clk_div + 1` system cycles, and the test clock is low whenever no sequence is shifting.
- R7: While a captured byte is waiting to be accepted, `in_ready` is low, and the byte stays stable until `out_ready` is seen.
- R8: After reset, the test clock is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Half-period of the test clock minus one, in system cycles |
| in_data | input | 8 | Command byte stream data |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Block accepts a command byte |
| out_data | output | 8 | Captured data-out byte |
| out_valid | output | 1 | Captured byte valid |
| out_ready | input | 1 | Downstream accepts the captured byte |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to the target |
| tdo | input | 1 | JTAG data from the target |

## Verification
Errors in the bit or byte counters appear at the pins within one sequence. They show up as an extra or missing test-clock rising edge, or as a data byte consumed too early, which also shifts every later descriptor. A wrong shift-register or packer state shows in the first mismatched data-pin bit at a rising edge, or in the first captured byte that reaches the output. A state machine that leaves the emit state early, or accepts input during it, is exposed by a random stall on `out_ready` in the same cycle.

// File: rtl/jseq_pkg.sv
package jseq_pkg;
    localparam int BYTE_W   = 8;
    localparam int LEN_W    = 6;
    localparam int BITS_W   = LEN_W + 1;
    localparam int BIDX_W   = $clog2(BYTE_W);
    localparam int TMS_POS  = 6;
    localparam int CAP_POS  = 7;

    typedef enum logic [2:0] {
        S_COUNT,
        S_DESC,
        S_LOAD,
        S_SHIFT,
        S_EMIT
    } seq_state_t;
endpackage

// File: rtl/jseq_tck_gen.sv
module jseq_tck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_m1,
    output logic             tck,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = run && (cnt >= half_m1);
    assign rise = wrap && !tck;
    assign fall = wrap && tck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            tck <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
            tck <= ~tck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: a running divider toggles only after the counter reaches the limit
    a_r6_toggle_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(tck)) |-> $past(cnt >= half_m1));
endmodule

// File: rtl/jseq_cap_pack.sv
module jseq_cap_pack #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] data_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (clr) begin
            sr  <= '0;
            cnt <= '0;
        end else if (shift) begin
            sr  <= {bit_in, sr[W-1:1]};
            cnt <= cnt + 1'b1;
        end
    end

    assign data_o = sr >> (CW'(W) - cnt);

    // R4: never more bits than one byte between clears
    a_r4_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clr) |-> (cnt < CW'(W)));
endmodule

// File: rtl/jseq_shifter.sv
module jseq_shifter
    import jseq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    input  logic             tdo
);
    seq_state_t        state, state_nx;
    logic [BYTE_W-1:0] seq_left;
    logic [BITS_W-1:0] bits_left;
    logic [BIDX_W-1:0] byte_bits;
    logic [BYTE_W-1:0] tdi_sr;
    logic              tms_r, cap_r, tdi_r;
    logic              acc, rise, fall, last_bit, seg_end;
    logic [BITS_W-1:0] desc_bits;

    assign in_ready  = (state == S_COUNT) || (state == S_DESC) || (state == S_LOAD);
    assign acc       = in_valid && in_ready;
    assign last_bit  = (bits_left == BITS_W'(1));
    assign seg_end   = last_bit || (byte_bits == BIDX_W'(BYTE_W - 1));
    assign desc_bits = (in_data[LEN_W-1:0] == '0) ? BITS_W'(64)
                                                  : {1'b0, in_data[LEN_W-1:0]};

    jseq_tck_gen #(.DIV_W(DIV_W)) u_tck (
        .clk(clk), .rst_n(rst_n), .run(state == S_SHIFT), .half_m1(clk_div),
        .tck(tck), .rise(rise), .fall(fall)
    );

    jseq_cap_pack #(.W(BYTE_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(acc && state == S_LOAD),
        .shift(rise), .bit_in(tdo), .data_o(out_data)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            S_COUNT: if (acc && in_data != '0) state_nx = S_DESC;
            S_DESC:  if (acc) state_nx = S_LOAD;
            S_LOAD:  if (acc) state_nx = S_SHIFT;
            S_SHIFT: if (fall && seg_end) begin
                if (cap_r)         state_nx = S_EMIT;
                else if (!last_bit) state_nx = S_LOAD;
                else               state_nx = (seq_left == '0) ? S_COUNT : S_DESC;
            end
            S_EMIT:  if (out_ready) begin
                if (bits_left != '0) state_nx = S_LOAD;
                else                 state_nx = (seq_left == '0) ? S_COUNT : S_DESC;
            end
            default: state_nx = S_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_COUNT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_left  <= '0;
            bits_left <= '0;
            byte_bits <= '0;
            tdi_sr    <= '0;
            tms_r     <= 1'b0;
            cap_r     <= 1'b0;
            tdi_r     <= 1'b0;
        end else begin
            unique case (state)
                S_COUNT: if (acc) seq_left <= in_data;
                S_DESC: if (acc) begin
                    seq_left  <= seq_left - 1'b1;
                    bits_left <= desc_bits;
                    tms_r     <= in_data[TMS_POS];
                    cap_r     <= in_data[CAP_POS];
                end
                S_LOAD: if (acc) begin
                    tdi_r     <= in_data[0];
                    tdi_sr    <= in_data >> 1;
                    byte_bits <= '0;
                end
                S_SHIFT: if (fall) begin
                    bits_left <= bits_left - 1'b1;
                    byte_bits <= byte_bits + 1'b1;
                    if (!seg_end) begin
                        tdi_r  <= tdi_sr[0];
                        tdi_sr <= tdi_sr >> 1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign tms       = tms_r;
    assign tdi       = tdi_r;
    assign out_valid = (state == S_EMIT);

    // R1: a shifting sequence always has clocks left to give
    a_r1_bits_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT) |-> (bits_left != '0));
    // R2: mode select does not move inside a shifting run
    a_r2_tms_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT && $past(state) == S_SHIFT) |-> $stable(tms));
    // R3: data pin moves only with the test clock low
    a_r3_tdi_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tdi) |-> !tck);
    // R6: test clock parked low outside shifting
    a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_SHIFT) |-> !tck);
    // R7: no input while a captured byte waits, and the byte holds
    a_r7_no_input_on_emit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/jseq_shifter_tb.sv
module jseq_shifter_tb;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] clk_div = '0;
    logic [7:0]       in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       out_data;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic             tck, tms, tdi;
    logic             tdo;

    always #2.5 clk = ~clk;

    jseq_shifter #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic       act_tdi [0:1023];
    logic       act_tms [0:1023];
    logic [7:0] act_out [0:255];
    logic       exp_tdi [0:1023];
    logic       exp_tms [0:1023];
    logic [7:0] exp_out [0:255];
    int act_n = 0, out_n = 0, g_rise = 0;
    int stall_pct = 0;
    bit gaps = 0;
    int hi_cnt = 0;
    logic prev_tck = 1'b0;

    logic [7:0] sq_desc [0:7];
    logic [7:0] sq_data [0:7][0:7];

    function automatic logic pat(input int unsigned k);
        logic [31:0] h;
        h = k * 32'h9E37_79B1;
        return h[17] ^ h[5];
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial tdo = pat(0);
    always @(negedge tck) tdo = pat(g_rise);
    always @(posedge tck) begin
        if (act_n < 1024) begin
            act_tdi[act_n] = tdi;
            act_tms[act_n] = tms;
        end
        act_n++;
        g_rise++;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            out_ready = ($urandom % 100) >= stall_pct;
            if (out_valid) check(!in_ready, "R7 in_ready during emit", in_ready, 0);
            if (out_valid && out_ready) begin
                if (out_n < 256) act_out[out_n] = out_data;
                out_n++;
            end
            if (tck) hi_cnt++;
            else if (prev_tck) begin
                check(hi_cnt == int'(clk_div) + 1, "R6 high phase", hi_cnt, int'(clk_div) + 1);
                hi_cnt = 0;
            end
            prev_tck = tck;
        end
    end

    task automatic send(input logic [7:0] b);
        if (gaps && ($urandom % 4 == 0)) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        in_data  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_cmd(input int nseq, input string name);
        int idx, eo, base;
        base = g_rise;
        act_n = 0;
        out_n = 0;
        idx = 0;
        eo = 0;
        for (int s = 0; s < nseq; s++) begin
            int nb;
            nb = (sq_desc[s][5:0] == 0) ? 64 : int'(sq_desc[s][5:0]);
            for (int b = 0; b < nb; b++) begin
                exp_tdi[idx + b] = sq_data[s][b / 8][b % 8];
                exp_tms[idx + b] = sq_desc[s][6];
            end
            if (sq_desc[s][7]) begin
                for (int k = 0; k < (nb + 7) / 8; k++) begin
                    logic [7:0] v;
                    v = '0;
                    for (int j = 0; j < 8; j++)
                        if (k * 8 + j < nb) v[j] = pat(base + idx + k * 8 + j);
                    exp_out[eo] = v;
                    eo++;
                end
            end
            idx += nb;
        end
        send(8'(nseq));
        for (int s = 0; s < nseq; s++) begin
            int nb;
            nb = (sq_desc[s][5:0] == 0) ? 64 : int'(sq_desc[s][5:0]);
            send(sq_desc[s]);
            for (int k = 0; k < (nb + 7) / 8; k++) send(sq_data[s][k]);
        end
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        check(act_n == idx, {"R1 clock count ", name}, act_n, idx);
        for (int i = 0; i < idx && i < act_n; i++) begin
            check(act_tdi[i] == exp_tdi[i], {"R3 tdi bit ", name}, act_tdi[i], exp_tdi[i]);
            check(act_tms[i] == exp_tms[i], {"R2 tms bit ", name}, act_tms[i], exp_tms[i]);
        end
        check(out_n == eo, {"R4 captured byte count ", name}, out_n, eo);
        for (int i = 0; i < eo && i < out_n; i++)
            check(act_out[i] == exp_out[i], {"R4 captured byte ", name}, act_out[i], exp_out[i]);
        check(tck == 1'b0, {"R6 idle tck ", name}, tck, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(tck == 1'b0, "R8 reset tck", tck, 0);
        check(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R8 reset in_ready", in_ready, 1);

        // R5: zero count gives no clocks, then a one-sequence command still frames
        run_cmd(0, "zero count");
        sq_desc[0] = 8'h83;
        sq_data[0][0] = 8'h05;
        run_cmd(1, "after zero");

        // R1 64 clocks, R2 both levels, R4 partial and full capture bytes
        clk_div = 8'd1;
        sq_desc[0] = 8'h00;
        for (int k = 0; k < 8; k++) sq_data[0][k] = 8'(8'hA5 ^ k * 8'h1D);
        sq_desc[1] = 8'hC5; sq_data[1][0] = 8'h1B;
        sq_desc[2] = 8'h88; sq_data[2][0] = 8'h96;
        sq_desc[3] = 8'hC0;
        for (int k = 0; k < 8; k++) sq_data[3][k] = 8'(k * 8'h37 + 8'h11);
        run_cmd(4, "directed");

        // R7: heavy stall on a single-bit capture and a 9-bit capture
        stall_pct = 85;
        clk_div = 8'd0;
        sq_desc[0] = 8'h81; sq_data[0][0] = 8'h01;
        sq_desc[1] = 8'hC9; sq_data[1][0] = 8'hFF; sq_data[1][1] = 8'h01;
        run_cmd(2, "stall");

        gaps = 1;
        for (int c = 0; c < 10; c++) begin
            int ns;
            stall_pct = int'($urandom % 60);
            clk_div = 8'($urandom % 3);
            ns = 1 + int'($urandom % 4);
            for (int s = 0; s < ns; s++) begin
                sq_desc[s] = 8'($urandom);
                for (int k = 0; k < 8; k++) sq_data[s][k] = 8'($urandom);
            end
            run_cmd(ns, "random");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule